// File: doc/BRIEF.md
# Multi-Mode Program ROM Bank Mapper

This block sits between a CPU and a cartridge program ROM built from 8 KB banks. It turns an address in the upper 32 KB CPU window ($8000-$FFFF), or in the optional lower window at $6000-$7FFF, into a ROM byte address. The ROM address is an 8 KB bank number followed by CPU address bits 12:0. The bank number comes from one of four 8-bit bank registers or from a fixed bank at the end of the ROM. A mode register picks one of four slot layouts. Two of its bits decide whether the top slot is switchable and whether the lower window reaches ROM.

Software programs the block with CPU writes to the $8000-$FFFF range. The translation is combinational, so `rom_addr` follows `cpu_addr` in the same cycle. Register writes take effect at the next rising clock edge. The number of 8 KB banks in the ROM is the parameter `BANKS`. Every bank number is folded into that range before it is used.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the four bank registers hold BANKS-4, BANKS-3, BANKS-2 and BANKS-1 (register 0 first). All mode fields are zero.
- R2: A write with `cpu_we` high is decoded on `cpu_addr & 16'hF007`. The values $8000, $8001, $8002 and $8003 load bank register 0, 1, 2 and 3. Every other decoded value leaves the bank registers unchanged, and only $D000 changes the mode.
- R3: A write that decodes to $D000 loads three mode fields from the data byte: window enable from bit 7, top-slot-switchable from bit 2, and layout from bits 1:0.
- R4: Layout 0 maps the 8 KB slots at $8000, $A000, $C000 and $E000 to banks BANKS-4, BANKS-3, BANKS-2 and BANKS-1.
- R5: Layout 1 maps bank 2*reg1 at $8000 and bank 2*reg1+1 at $A000. Banks BANKS-2 and BANKS-1 are fixed at $C000 and $E000.
- R6: Layout 2 with top-slot-switchable set maps registers 0, 1, 2 and 3 to the slots at $8000, $A000, $C000 and $E000.
- R7: Layout 2 with top-slot-switchable clear maps registers 0, 1 and 2 to the first three slots. Bank BANKS-1 is fixed at $E000.
- R8: In layout 2 with top-slot-switchable clear and window enable set, a read (`cpu_re` high) of $6000-$7FFF asserts `low_hit`. `rom_addr` then holds the bank in register 3.
- R9: Layout 3 maps registers 3, 2, 1 and 0 to the slots at $8000, $A000, $C000 and $E000.
- R10: Every bank number is taken modulo BANKS. `rom_addr` is that bank number concatenated with `cpu_addr[12:0]`.
- R11: `low_hit` is low in every other mode combination, for any address outside $6000-$7FFF, and whenever `cpu_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled at the rising edge |
| cpu_re | input | 1 | Read strobe, qualifies the lower-window hit |
| rom_addr | output | $clog2(BANKS)+13 | Program ROM byte address |
| low_hit | output | 1 | Lower window read is served from ROM |

## Verification
The hardest case to reach is the lower-window hit. It needs one exact combination of three mode fields, a read strobe and an address in a 8 KB range. Register 3 must also have been loaded, possibly through an aliased address. Directed writes first set each mode combination next to the hitting one and check that the window stays closed. Random traffic then mixes mode writes, aliased register writes and writes to unrelated offsets. It probes both windows, with the read strobe on and off, so the hit condition is reached many times from different register histories. Bank values above BANKS are written on purpose so that the modulo folding shows up in layouts 1 and 2.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int BANKS = 24,
  localparam int BW = $clog2(BANKS),
  localparam int AW = BW + 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  input  logic          cpu_we,
  input  logic          cpu_re,
  output logic [AW-1:0] rom_addr,
  output logic          low_hit
);

  logic [7:0] bank_q [4];
  logic       win_en, top_sw;
  logic [1:0] lay;
  logic [8:0] raw;

  wire [15:0] dec = cpu_addr & 16'hF007;
  wire wr_bank = cpu_we && (dec[15:2] == 14'h2000);
  wire wr_mode = cpu_we && (dec == 16'hD000);
  wire [1:0] slot = cpu_addr[14:13];
  wire unused_ok = ^{cpu_wdata[6:3], dec[11:3]};

  function automatic logic [BW-1:0] fold(input logic [8:0] v);
    return BW'(v % 9'(BANKS));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank_q[i] <= 8'(BANKS - 4 + i);
      win_en <= 1'b0;
      top_sw <= 1'b0;
      lay    <= 2'd0;
    end else begin
      if (wr_bank) bank_q[cpu_addr[1:0]] <= cpu_wdata;
      if (wr_mode) begin
        win_en <= cpu_wdata[7];
        top_sw <= cpu_wdata[2];
        lay    <= cpu_wdata[1:0];
      end
    end
  end

  always_comb begin
    if (!cpu_addr[15]) raw = {1'b0, bank_q[3]};
    else begin
      case (lay)
        2'd0: raw = 9'(BANKS - 4) + 9'(slot);
        2'd1: raw = slot[1] ? 9'(BANKS - 4) + 9'(slot) : {bank_q[1], slot[0]};
        2'd2: raw = (slot == 2'd3 && !top_sw) ? 9'(BANKS - 1) : {1'b0, bank_q[slot]};
        default: raw = {1'b0, bank_q[~slot]};
      endcase
    end
  end

  assign rom_addr = {fold(raw), cpu_addr[12:0]};
  assign low_hit  = cpu_re && (cpu_addr[15:13] == 3'b011) && (lay == 2'd2) && !top_sw && win_en;

  // R10
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rom_addr[AW-1:13]} < (BW+1)'(BANKS));

  // R8
  win_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_hit |-> cpu_re && cpu_addr[15:13] == 3'b011);

  // R2
  ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && dec[15:2] != 14'h2000) |=> $stable(bank_q[0]) && $stable(bank_q[1])
      && $stable(bank_q[2]) && $stable(bank_q[3]));

  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> lay == $past(cpu_wdata[1:0]) && top_sw == $past(cpu_wdata[2])
      && win_en == $past(cpu_wdata[7]));

  // R9
  reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lay == 2'd3 && cpu_addr[15:13] == 3'b100) |-> rom_addr[AW-1:13] == BW'({1'b0, bank_q[3]} % 9'(BANKS)));

endmodule

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;
  localparam int BANKS = 24;
  localparam int BW = $clog2(BANKS);
  localparam int AW = BW + 13;

  logic clk = 0, rst_n = 0, cpu_we = 0, cpu_re = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [7:0] cpu_wdata = 0;
  logic [AW-1:0] rom_addr;
  logic low_hit;
  int errors = 0, checks = 0;

  logic [7:0] m_reg [4];
  logic m_win, m_top;
  logic [1:0] m_lay;

  prg_bank_mapper #(.BANKS(BANKS)) uut (.*);

  always #5 clk = ~clk;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int exp_bank(input logic [15:0] a);
    int s = a[14:13];
    int v;
    if (!a[15]) v = m_reg[3];
    else case (m_lay)
      2'd0: v = BANKS - 4 + s;
      2'd1: v = (s == 0) ? 2*m_reg[1] : (s == 1) ? 2*m_reg[1] + 1 : BANKS - 4 + s;
      2'd2: v = (s == 3 && !m_top) ? BANKS - 1 : m_reg[s];
      default: v = m_reg[3 - s];
    endcase
    return v % BANKS;
  endfunction

  function automatic logic exp_hit(input logic [15:0] a, input logic re);
    return re && a[15:13] == 3'b011 && m_lay == 2'd2 && !m_top && m_win;
  endfunction

  function automatic string lay_tag(input logic [15:0] a);
    if (!a[15]) return "R8";
    case (m_lay)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return m_top ? "R6" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] dc = a & 16'hF007;
    if (dc[15:2] == 14'h2000) m_reg[dc[1:0]] = d;
    else if (dc == 16'hD000) begin
      m_win = d[7]; m_top = d[2]; m_lay = d[1:0];
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1;
    @(negedge clk);
    cpu_we = 0;
    model_write(a, d);
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic re);
    logic [AW-1:0] ea;
    logic eh;
    @(negedge clk);
    cpu_addr = a; cpu_re = re;
    #2;
    ea = {BW'(exp_bank(a)), a[12:0]};
    eh = exp_hit(a, re);
    checks++;
    if (low_hit !== eh) begin
      errors++;
      $display("FAIL %s low_hit addr=%h got=%b exp=%b", (a[15:13] == 3'b011) ? "R8/R11" : "R11", a, low_hit, eh);
    end
    if (a[15] || eh) begin
      checks++;
      if (rom_addr !== ea) begin
        errors++;
        $display("FAIL %s R10 rom_addr addr=%h got=%h exp=%h", tag, a, rom_addr, ea);
      end
    end
  endtask

  task automatic all_slots(input string tag);
    for (int s = 0; s < 4; s++) probe(tag, {1'b1, 2'(s), 13'(s * 813 + 5)}, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd5));
    for (int i = 0; i < 4; i++) m_reg[i] = 8'(BANKS - 4 + i);
    m_win = 0; m_top = 0; m_lay = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R4: reset banks in layout 0
    all_slots("R1");
    probe("R11", 16'h6123, 1'b1);
    // R2: aliased register writes and ignored offsets
    wr(16'h8FF8, 8'h03);
    wr(16'h8FF9, 8'h1D);
    wr(16'h8002, 8'h07);
    wr(16'h8FFB, 8'h09);
    wr(16'h8004, 8'h11);
    wr(16'h9001, 8'h12);
    wr(16'hB003, 8'h13);
    wr(16'hD004, 8'h06);
    // R6: still layout 0, then layout 2 with switchable top
    all_slots("R2");
    wr(16'hD000, 8'h06);
    all_slots("R6");
    probe("R11", 16'h7FFF, 1'b1);
    // R5 R10: register 1 folded
    wr(16'hD000, 8'h01);
    all_slots("R5");
    wr(16'h8001, 8'hFF);
    all_slots("R10");
    // R7 R8: fixed top, window open
    wr(16'hD000, 8'h82);
    all_slots("R7");
    probe("R8", 16'h6000, 1'b1);
    probe("R8", 16'h7ABC, 1'b1);
    probe("R11", 16'h6000, 1'b0);
    probe("R11", 16'h5FFF, 1'b1);
    wr(16'h8003, 8'hC8);
    probe("R8", 16'h6F00, 1'b1);
    // R11: window bit without fixed top, and fixed top without window bit
    wr(16'hD000, 8'h86);
    probe("R11", 16'h6400, 1'b1);
    wr(16'hD000, 8'h02);
    probe("R11", 16'h6400, 1'b1);
    wr(16'hD000, 8'h83);
    probe("R11", 16'h6400, 1'b1);
    // R9: reversed layout
    all_slots("R9");
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 99);
      logic [15:0] a;
      if (k < 60) a = 16'h8000 | 16'($urandom_range(0, 511) << 3) | 16'($urandom_range(0, 3)) | (16'($urandom_range(0, 7)) << 12);
      else if (k < 80) a = 16'hD000 | (16'($urandom_range(0, 511)) << 3);
      else a = 16'h8000 | 16'($urandom_range(0, 32767));
      if (k >= 60 && k < 80 && $urandom_range(0, 1) == 1) wr(a, 8'h82);
      else wr(a, 8'($urandom));
      for (int p = 0; p < 2; p++) begin
        logic [15:0] pa = 16'h6000 + 16'($urandom_range(0, 16'h9FFF));
        probe(lay_tag(pa), pa, 1'($urandom_range(0, 1)));
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule